// File: doc/BRIEF.md
# Serial Receive Channel with Sticky Status

This block is the receive half of an asynchronous serial port. A frame receiver oversamples the serial input 16 times per bit and assembles characters LSB first. A status unit then latches each accepted character into a receive data register and keeps four sticky flags. Those flags are a data-ready flag and three error flags: overrun, parity mismatch and bad stop bit. A receive interrupt request follows the data-ready flag. A separate error interrupt request follows any error flag, and each request has its own enable. The oversampling strobe comes from an external baud source.

Software clears flags through a status register port with a read-then-write-0 rule. A DMA-style engine can instead pulse a data-read strobe, which drops the data-ready flag without any write. While any error flag is set, the channel accepts no further characters and sets no further flags. This freeze lasts until all error flags are cleared. The synchronized line level is exported so that software can tell a held-low break from a single bad stop bit.

The frame receiver is a five-state machine:

- **IDLE** moves to **START** on an oversampling tick that sees the line low.
- **START** returns to **IDLE** if the line is high at the half-bit point (a glitch). Otherwise it moves to **DATA**.
- **DATA** samples each bit at mid-bit. After the last bit it moves to **PARITY** when parity is enabled, or to **STOP** when it is not.
- **PARITY** captures the parity bit and moves to **STOP**.
- **STOP** samples the stop bit, emits a one-cycle completion pulse and returns to **IDLE**.
- Dropping the enable forces **IDLE** from any state.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset the status is 4'b0000, the data register is 0, both interrupt requests are low and the exported line level is 1.
- R2: With reception enabled, a frame made of a low start bit, 8 data bits LSB first and a high stop bit (16 ticks per bit) is loaded into the data register and sets the ready flag (status bit 0).
- R3: With parity enabled, the bit after the data must make the total count of ones even (odd-select 0) or odd (odd-select 1). A mismatch sets the parity flag (status bit 2) and leaves the ready flag clear. A matching parity bit sets the ready flag.
- R4: A stop bit sampled low sets the framing flag (status bit 3), and the exported line level reads 0 while the line is held low.
- R5: If the ready flag is still 1 when a stop bit is sampled, the overrun flag (status bit 1) is set, the new character is discarded and the data register keeps the old value.
- R6: While any of status bits 3..1 is 1, arriving frames change neither the data register nor any flag.
- R7: A status write clears a flag only where the written bit is 0 and that flag was read as 1 by an earlier status read. A written 1 has no effect, and writing 0 without a prior read has no effect.
- R8: A DMA read strobe clears the ready flag in the next cycle without any status write.
- R9: The receive interrupt equals the ready flag gated by its enable. The error interrupt equals the OR of status bits 3..1 gated by its own enable. The two enables act independently.
- R10: A low pulse on the line shorter than half a bit period does not start a frame.
- R11: While reception is disabled no frame completes. A frame that is in progress when reception is disabled is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit period |
| rxd | input | 1 | Serial data input, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxi_en | input | 1 | Receive interrupt enable |
| eri_en | input | 1 | Error interrupt enable |
| stat_rd | input | 1 | Status register read strobe (arms clearing) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 4 | Status write data; a 0 bit clears an armed flag |
| dma_rd | input | 1 | DMA-side read strobe of the data register |
| stat | output | 4 | Flags: bit0 ready, bit1 overrun, bit2 parity, bit3 framing |
| rx_data | output | DATA_BITS (8) | Receive data register |
| rxd_level | output | 1 | Synchronized serial line level |
| rxi_irq | output | 1 | Receive interrupt request |
| eri_irq | output | 1 | Error interrupt request |

## Verification
A wrong bit counter or sampling point shows up in the data register as a shifted or corrupted byte. It appears two cycles after the stop bit is sampled. A faulty freeze or overrun decision appears in the status port and the data register at the next completed frame. A broken arming rule appears on the status port one cycle after the offending write. A DMA clear that is lost, or an interrupt gated by the wrong enable, is visible in the cycle after the strobe or enable change.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    localparam int NFLAGS = 4;
    localparam int F_RDY  = 0;
    localparam int F_OVR  = 1;
    localparam int F_PAR  = 2;
    localparam int F_FRM  = 3;

endpackage

// File: rtl/rxc_sync.sv
module rxc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rxc_frame.sv
module rxc_frame
    import rxc_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 par_en,
    input  logic                 par_odd,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 ferr
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] BLAST = BW'(DATA_BITS - 1);

    rx_state_e state, nxt;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bitcnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 pbit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (!en) state <= ST_IDLE;
        else          state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick && !line) nxt = ST_START;
            ST_START:  if (tick && cnt == MID) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (tick && cnt == LAST && bitcnt == BLAST)
                           nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick && cnt == LAST) nxt = ST_STOP;
            ST_STOP:   if (tick && cnt == LAST) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bitcnt <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            done   <= 1'b0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                cnt    <= '0;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        cnt    <= '0;
                        bitcnt <= '0;
                    end
                    ST_START: if (tick) cnt <= (cnt == MID) ? '0 : cnt + 1'b1;
                    ST_DATA: if (tick) begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            shreg  <= {line, shreg[DATA_BITS-1:1]};
                            bitcnt <= bitcnt + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PARITY: if (tick) begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            pbit <= line;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: if (tick) begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            done <= 1'b1;
                            ferr <= !line;
                            perr <= par_en && (((^shreg) ^ pbit) != par_odd);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    assign data = shreg;
endmodule

// File: rtl/rxc_status.sv
module rxc_status
    import rxc_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_done,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_perr,
    input  logic                 frm_ferr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [NFLAGS-1:0]    wdata,
    input  logic                 dma_rd,
    output logic [NFLAGS-1:0]    flags,
    output logic [DATA_BITS-1:0] rdata
);
    logic [NFLAGS-1:0]    flags_q, armed_q, nflags, narmed, clr;
    logic [DATA_BITS-1:0] data_q;
    logic                 err_any, accept, ready_now;

    always_comb begin
        err_any   = flags_q[F_OVR] | flags_q[F_PAR] | flags_q[F_FRM];
        clr       = wr ? (~wdata & armed_q) : '0;
        nflags    = flags_q & ~clr;
        if (dma_rd) nflags[F_RDY] = 1'b0;
        ready_now = nflags[F_RDY];
        accept    = frm_done & ~err_any;
        if (accept) begin
            if (ready_now) begin
                nflags[F_OVR] = 1'b1;
            end else if (frm_perr || frm_ferr) begin
                nflags[F_PAR] = frm_perr;
                nflags[F_FRM] = frm_ferr;
            end else begin
                nflags[F_RDY] = 1'b1;
            end
        end
        narmed = (armed_q | (rd ? flags_q : '0)) & ~clr & nflags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= nflags;
            armed_q <= narmed;
            if (accept && !ready_now) data_q <= frm_data;
        end
    end

    assign flags = flags_q;
    assign rdata = data_q;
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import rxc_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rxi_en,
    input  logic                 eri_en,
    input  logic                 stat_rd,
    input  logic                 stat_wr,
    input  logic [3:0]           stat_wdata,
    input  logic                 dma_rd,
    output logic [3:0]           stat,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rxd_level,
    output logic                 rxi_irq,
    output logic                 eri_irq
);
    logic                 line_s;
    logic                 frm_done, frm_perr, frm_ferr;
    logic [DATA_BITS-1:0] frm_data;

    rxc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rxc_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .tick   (tick16),
        .line   (line_s),
        .par_en (par_en),
        .par_odd(par_odd),
        .done   (frm_done),
        .data   (frm_data),
        .perr   (frm_perr),
        .ferr   (frm_ferr)
    );

    rxc_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_done(frm_done),
        .frm_data(frm_data),
        .frm_perr(frm_perr),
        .frm_ferr(frm_ferr),
        .rd      (stat_rd),
        .wr      (stat_wr),
        .wdata   (stat_wdata),
        .dma_rd  (dma_rd),
        .flags   (stat),
        .rdata   (rx_data)
    );

    assign rxd_level = line_s;
    assign rxi_irq   = rxi_en & stat[F_RDY];
    assign eri_irq   = eri_en & (stat[F_OVR] | stat[F_PAR] | stat[F_FRM]);
endmodule

// File: rtl/serial_rx_channel_chk.sv
module serial_rx_channel_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 dma_rd,
    input logic                 stat_wr,
    input logic [3:0]           stat_wdata,
    input logic [3:0]           stat,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 frame_done,
    input logic                 rxi_en,
    input logic                 rxi_irq,
    input logic                 eri_en,
    input logic                 eri_irq
);
    assert_dma_clears_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && !frame_done) |=> !stat[0]);

    assert_frozen_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat[3:1]) |=> $stable(rx_data));

    assert_frozen_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat[3:1]) |=> !$rose(stat[0]));

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && stat[0] && !(|stat[3:1]) && !dma_rd && !(stat_wr && !stat_wdata[0]))
        |=> (stat[1] && $stable(rx_data)));

    assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wdata[0] && stat[0] && !dma_rd) |=> stat[0]);

    assert_disabled_no_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frame_done);

    assert_rxi_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> (rxi_irq == rxi_en));

    assert_eri_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(eri_irq) && eri_en) |-> !(|stat[3:1]));
endmodule

bind serial_rx_channel serial_rx_channel_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .dma_rd    (dma_rd),
    .stat_wr   (stat_wr),
    .stat_wdata(stat_wdata),
    .stat      (stat),
    .rx_data   (rx_data),
    .frame_done(frm_done),
    .rxi_en    (rxi_en),
    .rxi_irq   (rxi_irq),
    .eri_en    (eri_en),
    .eri_irq   (eri_irq)
);

// File: tb/sim_serial_rx_channel.sv
module sim_serial_rx_channel;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxi_en = 1'b0;
    logic       eri_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic [3:0] stat_wdata = 4'hF;
    logic       dma_rd = 1'b0;
    logic [3:0] stat;
    logic [7:0] rx_data;
    logic       rxd_level, rxi_irq, eri_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .rxi_en(rxi_en), .eri_en(eri_en),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .dma_rd(dma_rd), .stat(stat), .rx_data(rx_data),
        .rxd_level(rxd_level), .rxi_irq(rxi_irq), .eri_irq(eri_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // drop_bit: frame bit index (0 = start) at which rx_en is pulled low, -1 for none
    task automatic send_frame(input logic [7:0] b, input logic bad_par,
                              input logic stop_v, input int drop_bit);
        logic p;
        p = (^b) ^ par_odd ^ bad_par;
        if (drop_bit == 0) rx_en = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (drop_bit == i + 1) rx_en = 1'b0;
            drive_bit(b[i]);
        end
        if (par_en) drive_bit(p);
        drive_bit(stop_v);
        rxd = 1'b1;
        idle(6);
    endtask

    task automatic st_read();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic st_write(input logic [3:0] w);
        stat_wdata = w; stat_wr = 1'b1; @(negedge clk); stat_wr = 1'b0; stat_wdata = 4'hF;
    endtask

    task automatic dma_pulse();
        dma_rd = 1'b1; @(negedge clk); dma_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 stat", stat, 4'h0);
        chk("R1 data", rx_data, 8'h00);
        chk("R1 rxi", rxi_irq, 1'b0);
        chk("R1 eri", eri_irq, 1'b0);
        chk("R1 level", rxd_level, 1'b1);
    endtask

    task automatic t_basic();
        rx_en = 1'b1; rxi_en = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b1, -1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 stat", stat, 4'h1);
        chk("R9 rxi on", rxi_irq, 1'b1);
        rxi_en = 1'b0; @(negedge clk);
        chk("R9 rxi gated", rxi_irq, 1'b0);
        rxi_en = 1'b1;
        dma_pulse();
        chk("R8 dma clear", stat, 4'h0);
        chk("R9 rxi off", rxi_irq, 1'b0);
    endtask

    task automatic t_clear_rule();
        send_frame(8'h3C, 1'b0, 1'b1, -1);
        chk("R2 data 3C", rx_data, 8'h3C);
        st_write(4'h0);
        chk("R7 no read no clear", stat, 4'h1);
        st_read();
        st_write(4'hF);
        chk("R7 write one kept", stat, 4'h1);
        st_write(4'hE);
        chk("R7 armed clear", stat, 4'h0);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 1'b0, 1'b1, -1);
        send_frame(8'h22, 1'b0, 1'b1, -1);
        chk("R5 stat", stat, 4'h3);
        chk("R5 data kept", rx_data, 8'h11);
        eri_en = 1'b1; @(negedge clk);
        chk("R9 eri on", eri_irq, 1'b1);
        eri_en = 1'b0; @(negedge clk);
        chk("R9 eri gated", eri_irq, 1'b0);
        chk("R9 rxi independent", rxi_irq, 1'b1);
        dma_pulse();
        send_frame(8'h33, 1'b0, 1'b1, -1);
        chk("R6 frozen data", rx_data, 8'h11);
        chk("R6 frozen stat", stat, 4'h2);
        st_read();
        st_write(4'h0);
        chk("R7 clear ovr", stat, 4'h0);
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b1, -1);
        chk("R3 even ok", stat, 4'h1);
        chk("R3 even data", rx_data, 8'h5A);
        dma_pulse();
        send_frame(8'h5B, 1'b1, 1'b1, -1);
        chk("R3 even bad", stat, 4'h4);
        st_read(); st_write(4'h0);
        chk("R3 clear", stat, 4'h0);
        par_odd = 1'b1;
        send_frame(8'hC3, 1'b0, 1'b1, -1);
        chk("R3 odd ok", stat, 4'h1);
        chk("R3 odd data", rx_data, 8'hC3);
        dma_pulse();
        send_frame(8'hC4, 1'b1, 1'b1, -1);
        chk("R3 odd bad", stat, 4'h4);
        st_read(); st_write(4'h0);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 1'b0, 1'b0, -1);
        chk("R4 stat", stat, 4'h8);
        chk("R4 data", rx_data, 8'h81);
        rxd = 1'b0; idle(40);
        chk("R4 break level", rxd_level, 1'b0);
        chk("R6 break frozen", stat, 4'h8);
        rxd = 1'b1; idle(300);
        chk("R6 after break", stat, 4'h8);
        st_read(); st_write(4'h0);
        chk("R7 clear frm", stat, 4'h0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0; idle(4); rxd = 1'b1; idle(300);
        chk("R10 glitch", stat, 4'h0);
        send_frame(8'h6E, 1'b0, 1'b1, -1);
        chk("R10 after glitch", rx_data, 8'h6E);
        dma_pulse();
    endtask

    task automatic t_disable();
        rx_en = 1'b0;
        send_frame(8'h44, 1'b0, 1'b1, -1);
        chk("R11 disabled", stat, 4'h0);
        rx_en = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b1, 3);
        rx_en = 1'b1; idle(300);
        chk("R11 abandoned", stat, 4'h0);
        chk("R11 data kept", rx_data, 8'h6E);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(3);
        t_basic();
        t_clear_rule();
        t_overrun();
        t_parity();
        t_framing();
        t_glitch();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule